// File: doc/BRIEF.md
# Bypass Threshold Sampling Tuner

This controller searches at run time for the warp-index threshold below which warps keep using a cache and at or above which they bypass it. On a start request it latches the warp count per thread block, W. It then launches one timed sample for each candidate threshold 0, 1, ..., W, strictly one after another. The external workload runs one whole thread block under the offered threshold and answers with a done pulse. A saturating cycle counter times each sample, and the result is merged into a running best. The best is replaced only when the new time is strictly smaller.

When the sweep ends, the block publishes the winning threshold and a mode word. A winner of 0 collapses to a uniform bypass-all mode. A winner of W collapses to a uniform cache-all mode. Any other winner selects conditional caching at that threshold. A one-cycle done pulse marks the moment the new result appears. The published values then hold until the next sweep completes.

Top module: `bypass_thr_tuner`

## Requirements
- R1: After reset, launch_o and done_o are 0, best_thr_o is 0 and mode_o is 2'b00.
- R2: A sweep launches candidate thresholds 0, 1, ..., W in ascending order on launch_thr_o, each with a one-cycle launch_o pulse, for exactly W+1 launches.
- R3: Only one sample is outstanding at a time. After a launch, launch_o stays low until sample_done_i has been seen, and then pulses in the very next cycle if candidates remain.
- R4: The elapsed time of a sample is the number of cycles from the launch cycle to the cycle in which sample_done_i is seen, minus one. The published threshold is the candidate with the smallest elapsed time.
- R5: When two candidates have equal elapsed time, the lower threshold wins.
- R6: The elapsed counter saturates at 2^CNT_W-1 instead of wrapping. All saturated samples count as that same worst time, and R5 applies among them.
- R7: The mode_o encoding is 2'b01 (bypass-all) when the winner is 0, which includes the case W=0. It is 2'b10 (cache-all) when the winner equals a nonzero W. Otherwise it is 2'b00 (conditional) with best_thr_o as the threshold.
- R8: done_o is high for exactly one cycle, two cycles after the cycle in which the last sample_done_i is seen. best_thr_o and mode_o change only in that cycle and hold until the next sweep completes.
- R9: start_i is ignored while a sweep is in progress.
- R10: A warps_i value above MAX_WARPS is clamped to MAX_WARPS.
- R11: sample_done_i is ignored when no sample is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep when idle |
| warps_i | input | THR_W | Warps per thread block, W |
| launch_o | output | 1 | One-cycle pulse launching a sample |
| launch_thr_o | output | THR_W | Candidate threshold for the launched sample |
| sample_done_i | input | 1 | Completion pulse of the outstanding sample |
| best_thr_o | output | THR_W | Winning threshold |
| mode_o | output | 2 | 00 conditional, 01 bypass-all, 10 cache-all |
| done_o | output | 1 | One-cycle pulse when a result is published |

## Verification
The bench builds the tuner with MAX_WARPS=8 and CNT_W=6. This keeps a full sweep to at most nine samples and puts the counter ceiling at 63 cycles, so a sample delayed by 70 cycles reaches saturation cheaply. The narrow warp field also lets a request of 12 warps show the clamp to 8. A zero-warp request shows that a one-sample sweep collapses to bypass-all.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    MODE_COND       = 2'd0,
    MODE_BYPASS_ALL = 2'd1,
    MODE_CACHE_ALL  = 2'd2
  } mode_t;
endpackage

// File: rtl/tuner_seq.sv
module tuner_seq
  import tuner_pkg::*;
#(
  parameter int MAX_WARPS = 32,
  parameter int THR_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [THR_W-1:0] warps_i,
  input  logic             sample_done_i,
  output logic             launch_o,
  output logic [THR_W-1:0] cand_o,
  output logic [THR_W-1:0] wlim_o,
  output logic             init_o,
  output logic             merge_o,
  output logic             finish_o,
  output logic             tmr_clr_o,
  output logic             tmr_en_o
);
  localparam logic [THR_W-1:0] MAXW = THR_W'(MAX_WARPS);

  seq_st_t          st_q, st_d;
  logic [THR_W-1:0] cand_q, cand_d;
  logic [THR_W-1:0] wlim_q, wlim_d;
  logic             cand_en, wlim_en;
  logic             last_c;

  assign last_c = (cand_q == wlim_q);

  always_comb begin
    st_d    = st_q;
    cand_d  = cand_q;
    wlim_d  = wlim_q;
    cand_en = 1'b0;
    wlim_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d    = ST_LAUNCH;
        cand_d  = '0;
        cand_en = 1'b1;
        wlim_d  = (warps_i > MAXW) ? MAXW : warps_i;
        wlim_en = 1'b1;
      end
      ST_LAUNCH: st_d = ST_WAIT;
      ST_WAIT: if (sample_done_i) begin
        if (last_c) begin
          st_d = ST_FINISH;
        end else begin
          st_d    = ST_LAUNCH;
          cand_d  = cand_q + 1'b1;
          cand_en = 1'b1;
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cand_q <= '0;
      wlim_q <= '0;
    end else begin
      st_q <= st_d;
      if (cand_en) cand_q <= cand_d;
      if (wlim_en) wlim_q <= wlim_d;
    end
  end

  assign launch_o  = (st_q == ST_LAUNCH);
  assign cand_o    = cand_q;
  assign wlim_o    = wlim_q;
  assign init_o    = (st_q == ST_IDLE) && start_i;
  assign merge_o   = (st_q == ST_WAIT) && sample_done_i;
  assign finish_o  = (st_q == ST_FINISH);
  assign tmr_clr_o = (st_q == ST_LAUNCH);
  assign tmr_en_o  = (st_q == ST_WAIT) && !sample_done_i;

  // R3: a launch is always followed by at least one waiting cycle
  p_one_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> !launch_o);
  // R2: the candidate never passes the latched warp count
  p_cand_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (cand_q <= wlim_q));
  // R10: the latched warp count respects the ceiling
  p_clamp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (wlim_q <= MAXW));
  // R9: a start during a sweep leaves the latched count unchanged
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(wlim_q));
endmodule

// File: rtl/tuner_timer.sv
module tuner_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (en_i && (cnt_q != SAT)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6: the counter holds at its ceiling instead of wrapping
  p_hold_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && cnt_q == SAT) |=> (cnt_q == SAT));
  // R6: the counter never drops except through a clear
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/tuner_min.sv
module tuner_min #(
  parameter int THR_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             merge_i,
  input  logic [THR_W-1:0] cand_i,
  input  logic [CNT_W-1:0] elapsed_i,
  output logic [THR_W-1:0] best_thr_o
);
  logic [CNT_W-1:0] best_t_q;
  logic [THR_W-1:0] best_thr_q;
  logic             have_q;
  logic             take;

  assign take = merge_i && (!have_q || (elapsed_i < best_t_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      best_t_q   <= '0;
      best_thr_q <= '0;
    end else begin
      if (init_i) have_q <= 1'b0;
      else if (take) have_q <= 1'b1;
      if (take) begin
        best_t_q   <= elapsed_i;
        best_thr_q <= cand_i;
      end
    end
  end

  assign best_thr_o = best_thr_q;

  // R5: an equal or slower sample leaves the earlier winner in place
  p_keep_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_i && have_q && !init_i && (elapsed_i >= best_t_q)) |=> $stable(best_thr_q));
  // R4: the recorded best time never grows within a sweep
  p_best_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !init_i) |=> (best_t_q <= $past(best_t_q)));
endmodule

// File: rtl/tuner_result.sv
module tuner_result
  import tuner_pkg::*;
#(
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish_i,
  input  logic [THR_W-1:0] best_i,
  input  logic [THR_W-1:0] wlim_i,
  output logic [THR_W-1:0] best_thr_o,
  output logic [1:0]       mode_o,
  output logic             done_o
);
  mode_t            mode_d;
  logic [THR_W-1:0] thr_q;
  mode_t            mode_q;
  logic             done_q;

  always_comb begin
    if (best_i == '0)         mode_d = MODE_BYPASS_ALL;
    else if (best_i == wlim_i) mode_d = MODE_CACHE_ALL;
    else                      mode_d = MODE_COND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      mode_q <= MODE_COND;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_i;
      if (finish_i) begin
        thr_q  <= best_i;
        mode_q <= mode_d;
      end
    end
  end

  assign best_thr_o = thr_q;
  assign mode_o     = mode_q;
  assign done_o     = done_q;

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R8: published values move only when a sweep finishes
  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_i |=> ($stable(thr_q) && $stable(mode_q)));
  // R7: a collapsed mode never carries an inner threshold
  p_mode_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q == MODE_COND) |-> (thr_q != '0));
endmodule

// File: rtl/bypass_thr_tuner.sv
module bypass_thr_tuner #(
  parameter int MAX_WARPS = 32,
  parameter int CNT_W     = 16,
  localparam int THR_W    = $clog2(MAX_WARPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [THR_W-1:0] warps_i,
  output logic             launch_o,
  output logic [THR_W-1:0] launch_thr_o,
  input  logic             sample_done_i,
  output logic [THR_W-1:0] best_thr_o,
  output logic [1:0]       mode_o,
  output logic             done_o
);
  logic [THR_W-1:0] cand, wlim, best;
  logic [CNT_W-1:0] elapsed;
  logic             init, merge, finish, tclr, ten;

  tuner_seq #(.MAX_WARPS(MAX_WARPS), .THR_W(THR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .warps_i(warps_i),
    .sample_done_i(sample_done_i), .launch_o(launch_o), .cand_o(cand),
    .wlim_o(wlim), .init_o(init), .merge_o(merge), .finish_o(finish),
    .tmr_clr_o(tclr), .tmr_en_o(ten)
  );

  tuner_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tclr), .en_i(ten), .cnt_o(elapsed)
  );

  tuner_min #(.THR_W(THR_W), .CNT_W(CNT_W)) u_min (
    .clk(clk), .rst_n(rst_n), .init_i(init), .merge_i(merge),
    .cand_i(cand), .elapsed_i(elapsed), .best_thr_o(best)
  );

  tuner_result #(.THR_W(THR_W)) u_res (
    .clk(clk), .rst_n(rst_n), .finish_i(finish), .best_i(best),
    .wlim_i(wlim), .best_thr_o(best_thr_o), .mode_o(mode_o), .done_o(done_o)
  );

  assign launch_thr_o = cand;

  // R1/R8: no result pulse while a sample is being launched
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_o && done_o));
endmodule

// File: tb/sim_bypass_thr_tuner.sv
module sim_bypass_thr_tuner;
  localparam int MW = 8;
  localparam int CW = 6;
  localparam int TW = $clog2(MW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [TW-1:0] warps_i = '0;
  logic          launch_o;
  logic [TW-1:0] launch_thr_o;
  logic          sample_done_i = 1'b0;
  logic [TW-1:0] best_thr_o;
  logic [1:0]    mode_o;
  logic          done_o;

  int n_chk = 0;
  int n_bad = 0;
  int lat [0:15];

  always #4 clk = ~clk;

  bypass_thr_tuner #(.MAX_WARPS(MW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .warps_i(warps_i),
    .launch_o(launch_o), .launch_thr_o(launch_thr_o),
    .sample_done_i(sample_done_i), .best_thr_o(best_thr_o),
    .mode_o(mode_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one sweep; the responder answers each launch after lat[thr] cycles.
  task automatic run_sweep(input int w_in, input int w_eff, input bit poke,
                           input int exp_thr, input int exp_mode, input string req);
    int seen;
    int got;
    bit busy_ok;
    @(negedge clk);
    warps_i = TW'(w_in);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = 0;
    for (int s = 0; s <= w_eff; s++) begin
      got = 0;
      for (int t = 0; t < 10 && !got; t++) begin
        if (launch_o) got = 1;
        else @(negedge clk);
      end
      check(got == 1, "R2 launch seen", got, 1);
      check(int'(launch_thr_o) == s, "R2 candidate order", int'(launch_thr_o), s);
      seen++;
      busy_ok = 1'b1;
      for (int k = 0; k < lat[s]; k++) begin
        @(negedge clk);
        if (launch_o) busy_ok = 1'b0;
        if (poke && s == 1 && k == 0) begin
          warps_i = TW'(7);
          start_i = 1'b1;
        end else begin
          start_i = 1'b0;
        end
      end
      check(busy_ok, "R3 no launch while outstanding", int'(busy_ok), 1);
      sample_done_i = 1'b1;
      @(negedge clk);
      sample_done_i = 1'b0;
    end
    // R2: no further launch; R8: done two cycles after the last sample_done
    check(launch_o == 1'b0, "R2 no extra launch", int'(launch_o), 0);
    check(done_o == 1'b0, "R8 done not early", int'(done_o), 0);
    @(negedge clk);
    check(done_o == 1'b1, "R8 done timing", int'(done_o), 1);
    check(int'(best_thr_o) == exp_thr, req, int'(best_thr_o), exp_thr);
    check(int'(mode_o) == exp_mode, "R7 mode", int'(mode_o), exp_mode);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(int'(best_thr_o) == exp_thr && int'(mode_o) == exp_mode, "R8 result hold",
          int'(best_thr_o), exp_thr);
    check(launch_o == 1'b0, "R2 idle after sweep", int'(launch_o), 0);
  endtask

  task automatic t_reset();
    check(launch_o == 1'b0 && done_o == 1'b0, "R1 reset strobes", int'(launch_o) + int'(done_o), 0);
    check(best_thr_o == '0 && mode_o == 2'b00, "R1 reset result", int'(best_thr_o) + int'(mode_o), 0);
  endtask

  task automatic t_middle();
    lat[0] = 9; lat[1] = 7; lat[2] = 3; lat[3] = 8; lat[4] = 10;
    run_sweep(4, 4, 1'b0, 2, 0, "R4 middle minimum");
  endtask

  task automatic t_low_end();
    lat[0] = 2; lat[1] = 5; lat[2] = 6; lat[3] = 7; lat[4] = 8;
    run_sweep(4, 4, 1'b0, 0, 1, "R7 bypass-all winner");
  endtask

  task automatic t_high_end();
    lat[0] = 9; lat[1] = 8; lat[2] = 7; lat[3] = 6; lat[4] = 3;
    run_sweep(4, 4, 1'b0, 4, 2, "R7 cache-all winner");
  endtask

  task automatic t_tie();
    lat[0] = 6; lat[1] = 4; lat[2] = 9; lat[3] = 4; lat[4] = 7; lat[5] = 8;
    run_sweep(5, 5, 1'b0, 1, 0, "R5 tie keeps lower");
  endtask

  task automatic t_saturate();
    lat[0] = 80; lat[1] = 70; lat[2] = 90; lat[3] = 75;
    run_sweep(3, 3, 1'b0, 0, 1, "R6 all saturated");
    lat[0] = 80; lat[1] = 60; lat[2] = 70;
    run_sweep(2, 2, 1'b0, 1, 0, "R6 below ceiling wins");
  endtask

  task automatic t_zero_warps();
    lat[0] = 4;
    run_sweep(0, 0, 1'b0, 0, 1, "R7 zero warps");
  endtask

  task automatic t_clamp();
    for (int i = 0; i <= 8; i++) lat[i] = 12;
    lat[5] = 5;
    run_sweep(12, 8, 1'b0, 5, 0, "R10 clamped sweep");
  endtask

  task automatic t_busy_start();
    lat[0] = 9; lat[1] = 3; lat[2] = 6; lat[3] = 8;
    run_sweep(3, 3, 1'b1, 1, 0, "R9 start ignored when busy");
  endtask

  task automatic t_stray_done();
    bit quiet;
    quiet = 1'b1;
    @(negedge clk);
    sample_done_i = 1'b1;
    @(negedge clk);
    sample_done_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (launch_o || done_o) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R11 stray done ignored", int'(quiet), 1);
    check(int'(best_thr_o) == 1, "R11 result untouched", int'(best_thr_o), 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_middle();
    t_low_end();
    t_high_end();
    t_tie();
    t_saturate();
    t_zero_warps();
    t_clamp();
    t_busy_start();
    t_stray_done();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule